// File: doc/BRIEF.md
# Two-Input Fuzzy Inference Engine

This block is the inference core of a fuzzy controller. It takes two signed fixed-point inputs that the surrounding logic has already scaled: an error term and an error-change term. Each input is graded against eight evenly spaced, symmetric triangular sets. The block then fires a complete 8x8 rule table. It resolves the fired rules against eight singleton output positions, using a weighted average, into one signed control value. The rule table and the singleton positions are elaboration-time constants.

A one-cycle `start` qualifies the inputs. The result appears with a one-cycle `valid_o` pulse after a fixed two-edge pipeline. The pipeline accepts a new sample on every cycle. The input width, membership-degree width and output width are parameters. The two intended builds are 8-bit data with 6-bit degrees and 6-bit data with 4-bit degrees.

Top module: `fz_infer_core`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `valid_o` is 0 and `u_o` is 0. Asserting `rst_n` low clears both at once, without waiting for a clock edge.
- R2: A `start` sampled on clock edge N produces `valid_o` high between edges N+2 and N+3 only. Every sampled `start` gives exactly one pulse, including on back-to-back cycles. Without `start` there is no pulse, and `u_o` holds its last value.
- R3: With F = IN_W-3, set k (0..7) is a triangle centred at c_k = (2k-7)*2^(F-1), with half-width 2^F. Neighbouring sets overlap by half. For an input strictly between c_0 and c_7, let s = floor((x-c_0)/2^F) and f = (x-c_0) mod 2^F. Set s+1 then has degree f rescaled to MU_W bits by shifting, and set s has degree (2^MU_W-1) minus that value.
- R4: An input at or below c_0 gives set 0 the full degree 2^MU_W-1. An input at or above c_7 gives set 7 the full degree. All other sets are then 0.
- R5: The rule for error set i and change set j is the 3-bit field RULES[3*(8*i+j) +: 3], which selects an output singleton. The default table is (i+j)>>1.
- R6: A rule's firing strength is the minimum of the degrees of its two antecedent sets.
- R7: The output is sum(strength*singleton)/sum(strength), truncated toward zero and saturated to OUT_W bits. A total strength of zero gives 0.
- R8: Singleton k is the signed field SINGLE[k*OUT_W +: OUT_W]. The default value is (2k-7)*2^(OUT_W-4).
- R9: With IN_W=6, MU_W=4 and OUT_W=6, the same rules hold with the correspondingly rescaled centres, degrees and singletons.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Qualifies `err_i` and `derr_i` in this cycle |
| err_i | input | IN_W | Scaled error term, signed |
| derr_i | input | IN_W | Scaled error-change term, signed |
| valid_o | output | 1 | One-cycle result strobe |
| u_o | output | OUT_W | Defuzzified control value, signed |

## Verification
The bench targets inputs exactly on the outer centres and one code outside them. An off-by-one there would index a ninth set or leave the edge set below full degree, so the output would move away from the corner singleton. Inputs just inside c_7 and mixed mid-interval pairs fire four rules with unequal strengths. These expose any use of a product instead of the minimum, a wrong rescaling shift, or rounding instead of truncation in the divide. Back-to-back starts and idle stretches check that one pulse follows each sample at the fixed latency. They also check that `u_o` holds between results and clears at once on reset. A second, narrow instance checks that the centre and degree arithmetic follows the parameters.

// File: rtl/fz_pkg.sv
package fz_pkg;
  localparam int N_SETS = 8;
  localparam int SET_W  = 3;
  localparam int N_RULE = N_SETS * N_SETS;

  // Default rule table: output index (i+j)>>1 for error set i, change set j.
  function automatic logic [N_RULE*SET_W-1:0] fz_default_rules();
    logic [N_RULE*SET_W-1:0] res;
    res = '0;
    for (int i = 0; i < N_SETS; i++) begin
      for (int j = 0; j < N_SETS; j++) begin
        res[SET_W*(N_SETS*i+j) +: SET_W] = SET_W'((i + j) >> 1);
      end
    end
    return res;
  endfunction

  // Default singletons: (2k-7)*2^(ow-4), packed with stride ow (ow <= 16).
  function automatic logic [N_SETS*16-1:0] fz_default_singles(int ow);
    logic [N_SETS*16-1:0] res;
    int v;
    res = '0;
    for (int k = 0; k < N_SETS; k++) begin
      v = (2*k - 7) * (1 << (ow - 4));
      for (int b = 0; b < ow; b++) res[k*ow + b] = v[b];
    end
    return res;
  endfunction
endpackage

// File: rtl/fz_fuzzify.sv
module fz_fuzzify #(
  parameter int IN_W = 8,
  parameter int MU_W = 6
) (
  input  logic signed [IN_W-1:0] x,
  output logic [2:0]             seg,
  output logic [MU_W-1:0]        mu_lo,
  output logic [MU_W-1:0]        mu_hi
);
  localparam int F = IN_W - 3;
  localparam logic signed [IN_W:0] C0_S = (IN_W+1)'(-(7 << (F-1)));
  localparam logic signed [IN_W:0] C7_S = (IN_W+1)'(7 << (F-1));
  localparam logic [MU_W-1:0] FULL = {MU_W{1'b1}};

  logic signed [IN_W:0] x_ext;
  logic [IN_W-1:0]      off;
  logic [F-1:0]         frac;
  logic [MU_W-1:0]      frac_sc;

  assign x_ext = {x[IN_W-1], x};
  assign off   = IN_W'(x_ext - C0_S);
  assign frac  = off[F-1:0];

  generate
    if (MU_W > F) begin : g_up
      assign frac_sc = {frac, {(MU_W-F){1'b0}}};
    end else if (MU_W == F) begin : g_eq
      assign frac_sc = frac;
    end else begin : g_dn
      assign frac_sc = frac[F-1 -: MU_W];
    end
  endgenerate

  always_comb begin
    if (x_ext <= C0_S) begin
      seg   = 3'd0;
      mu_lo = FULL;
      mu_hi = '0;
    end else if (x_ext >= C7_S) begin
      seg   = 3'd6;
      mu_lo = '0;
      mu_hi = FULL;
    end else begin
      seg   = off[IN_W-1:F];
      mu_hi = frac_sc;
      mu_lo = FULL - frac_sc;
    end
  end
endmodule

// File: rtl/fz_rule_bank.sv
module fz_rule_bank #(
  parameter int MU_W  = 6,
  parameter int OUT_W = 8,
  parameter int NUM_W = MU_W + OUT_W + 3,
  parameter int DEN_W = MU_W + 2,
  parameter logic [fz_pkg::N_RULE*fz_pkg::SET_W-1:0] RULES = fz_pkg::fz_default_rules(),
  parameter logic [fz_pkg::N_SETS*OUT_W-1:0] SINGLE =
    (fz_pkg::N_SETS*OUT_W)'(fz_pkg::fz_default_singles(OUT_W))
) (
  input  logic [2:0]              seg_e,
  input  logic [MU_W-1:0]         mu_e_lo,
  input  logic [MU_W-1:0]         mu_e_hi,
  input  logic [2:0]              seg_d,
  input  logic [MU_W-1:0]         mu_d_lo,
  input  logic [MU_W-1:0]         mu_d_hi,
  output logic signed [NUM_W-1:0] num,
  output logic [DEN_W-1:0]        den
);
  localparam int SW = fz_pkg::SET_W;

  logic signed [NUM_W-1:0] prod [4];
  logic [MU_W-1:0]         wgt  [4];

  // Four candidate rules: lower/upper set of each input.
  generate
    for (genvar r = 0; r < 4; r++) begin : g_rule
      logic [2:0]           ie, id;
      logic [MU_W-1:0]      me, md;
      logic [SW-1:0]        code;
      logic signed [OUT_W-1:0] val;
      assign ie   = seg_e + 3'((r >> 1) & 1);
      assign id   = seg_d + 3'(r & 1);
      assign me   = ((r >> 1) & 1) != 0 ? mu_e_hi : mu_e_lo;
      assign md   = (r & 1) != 0 ? mu_d_hi : mu_d_lo;
      assign code = RULES[SW*(8*int'(ie) + int'(id)) +: SW];
      assign val  = SINGLE[int'(code)*OUT_W +: OUT_W];
      assign wgt[r]  = (me < md) ? me : md;
      assign prod[r] = $signed({{(NUM_W-MU_W){1'b0}}, wgt[r]}) *
                       $signed({{(NUM_W-OUT_W){val[OUT_W-1]}}, val});
    end
  endgenerate

  always_comb begin
    num = '0;
    den = '0;
    for (int r = 0; r < 4; r++) begin
      num = num + prod[r];
      den = den + DEN_W'(wgt[r]);
    end
  end
endmodule

// File: rtl/fz_defuzz.sv
module fz_defuzz #(
  parameter int OUT_W = 8,
  parameter int NUM_W = 17,
  parameter int DEN_W = 8
) (
  input  logic signed [NUM_W-1:0] num,
  input  logic [DEN_W-1:0]        den,
  output logic signed [OUT_W-1:0] q
);
  localparam logic signed [NUM_W-1:0] QMAX = NUM_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [NUM_W-1:0] QMIN = -NUM_W'(1 << (OUT_W-1));

  logic signed [NUM_W-1:0] dv;
  logic signed [NUM_W-1:0] quo;

  assign dv = $signed({{(NUM_W-DEN_W){1'b0}}, den});

  always_comb begin
    quo = '0;
    if (den != '0) quo = num / dv;
    if (quo > QMAX)      q = QMAX[OUT_W-1:0];
    else if (quo < QMIN) q = QMIN[OUT_W-1:0];
    else                 q = quo[OUT_W-1:0];
  end
endmodule

// File: rtl/fz_infer_core.sv
module fz_infer_core #(
  parameter int IN_W  = 8,
  parameter int MU_W  = 6,
  parameter int OUT_W = 8,
  parameter logic [fz_pkg::N_RULE*fz_pkg::SET_W-1:0] RULES = fz_pkg::fz_default_rules(),
  parameter logic [fz_pkg::N_SETS*OUT_W-1:0] SINGLE =
    (fz_pkg::N_SETS*OUT_W)'(fz_pkg::fz_default_singles(OUT_W))
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [IN_W-1:0]  err_i,
  input  logic signed [IN_W-1:0]  derr_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] u_o
);
  localparam int NUM_W = MU_W + OUT_W + 3;
  localparam int DEN_W = MU_W + 2;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  // Fuzzification of both inputs.
  logic signed [IN_W-1:0] x_in  [2];
  logic [2:0]             fz_seg[2];
  logic [MU_W-1:0]        fz_lo [2];
  logic [MU_W-1:0]        fz_hi [2];
  assign x_in[0] = err_i;
  assign x_in[1] = derr_i;

  generate
    for (genvar c = 0; c < 2; c++) begin : g_fz
      fz_fuzzify #(.IN_W(IN_W), .MU_W(MU_W)) u_fz (
        .x(x_in[c]), .seg(fz_seg[c]), .mu_lo(fz_lo[c]), .mu_hi(fz_hi[c])
      );
    end
  endgenerate

  // Stage 1: membership registers.
  logic            s1_v;
  logic [2:0]      s1_seg[2];
  logic [MU_W-1:0] s1_lo [2];
  logic [MU_W-1:0] s1_hi [2];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s1_v <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        s1_seg[c] <= '0;
        s1_lo[c]  <= '0;
        s1_hi[c]  <= '0;
      end
    end else begin
      s1_v <= start;
      if (start) begin
        for (int c = 0; c < 2; c++) begin
          s1_seg[c] <= fz_seg[c];
          s1_lo[c]  <= fz_lo[c];
          s1_hi[c]  <= fz_hi[c];
        end
      end
    end
  end

  // Rule evaluation.
  logic signed [NUM_W-1:0] rb_num;
  logic [DEN_W-1:0]        rb_den;

  fz_rule_bank #(
    .MU_W(MU_W), .OUT_W(OUT_W), .NUM_W(NUM_W), .DEN_W(DEN_W),
    .RULES(RULES), .SINGLE(SINGLE)
  ) u_rules (
    .seg_e(s1_seg[0]), .mu_e_lo(s1_lo[0]), .mu_e_hi(s1_hi[0]),
    .seg_d(s1_seg[1]), .mu_d_lo(s1_lo[1]), .mu_d_hi(s1_hi[1]),
    .num(rb_num), .den(rb_den)
  );

  // Stage 2: weighted sums.
  logic                    s2_v;
  logic signed [NUM_W-1:0] s2_num;
  logic [DEN_W-1:0]        s2_den;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      s2_v   <= 1'b0;
      s2_num <= '0;
      s2_den <= '0;
    end else begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_num <= rb_num;
        s2_den <= rb_den;
      end
    end
  end

  // Defuzzification and output register.
  logic signed [OUT_W-1:0] dz_q;

  fz_defuzz #(.OUT_W(OUT_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_dz (
    .num(s2_num), .den(s2_den), .q(dz_q)
  );

  logic                    valid_d;
  logic signed [OUT_W-1:0] u_d;

  always_comb begin
    valid_d = s2_v;
    u_d     = s2_v ? dz_q : u_o;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_o <= 1'b0;
      u_o     <= '0;
    end else begin
      valid_o <= valid_d;
      u_o     <= u_d;
    end
  end
endmodule

// File: rtl/fz_infer_core_chk.sv
module fz_infer_core_chk #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter logic [fz_pkg::N_RULE*fz_pkg::SET_W-1:0] RULES = '0,
  parameter logic [fz_pkg::N_SETS*OUT_W-1:0] SINGLE = '0
) (
  input logic                    clk,
  input logic                    srst_n,
  input logic                    start,
  input logic signed [IN_W-1:0]  err_i,
  input logic signed [IN_W-1:0]  derr_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] u_o
);
  localparam int F  = IN_W - 3;
  localparam int C0 = -(7 << (F-1));
  localparam int C7 = 7 << (F-1);

  function automatic int sng(int k);
    logic signed [OUT_W-1:0] v;
    v = SINGLE[k*OUT_W +: OUT_W];
    return int'(v);
  endfunction

  function automatic int s_min();
    int m = sng(0);
    for (int k = 1; k < 8; k++) if (sng(k) < m) m = sng(k);
    return m;
  endfunction

  function automatic int s_max();
    int m = sng(0);
    for (int k = 1; k < 8; k++) if (sng(k) > m) m = sng(k);
    return m;
  endfunction

  localparam int SMIN = s_min();
  localparam int SMAX = s_max();
  localparam int U_HI = sng(int'(RULES[3*63 +: 3]));
  localparam int U_LO = sng(int'(RULES[2:0]));

  // R1: pipeline output quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !srst_n |-> (!valid_o && u_o == '0));

  // R2: each sampled start yields a pulse two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (!srst_n)
    start |-> ##3 valid_o);

  // R2: no pulse without a start
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!srst_n)
    valid_o |-> $past(start, 3));

  // R2: output holds between results
  a_r2_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !valid_o |-> $stable(u_o));

  // R4: both inputs at or beyond the top centre give rule (7,7)
  a_r4_sat_high: assert property (@(posedge clk) disable iff (!srst_n)
    (start && int'(err_i) >= C7 && int'(derr_i) >= C7) |-> ##3 (int'(u_o) == U_HI));

  // R4: both inputs at or below the bottom centre give rule (0,0)
  a_r4_sat_low: assert property (@(posedge clk) disable iff (!srst_n)
    (start && int'(err_i) <= C0 && int'(derr_i) <= C0) |-> ##3 (int'(u_o) == U_LO));

  // R7: weighted average stays within the singleton span
  a_r7_in_span: assert property (@(posedge clk) disable iff (!srst_n)
    valid_o |-> (int'(u_o) >= SMIN && int'(u_o) <= SMAX));
endmodule

bind fz_infer_core fz_infer_core_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .RULES(RULES), .SINGLE(SINGLE)
) u_chk (
  .clk(clk), .srst_n(srst_n), .start(start), .err_i(err_i),
  .derr_i(derr_i), .valid_o(valid_o), .u_o(u_o)
);

// File: tb/fz_infer_core_tb_top.sv
`timescale 1ns/1ps
module fz_infer_core_tb_top;
  logic clk;
  logic rst_n;
  logic start;
  logic signed [7:0] err, derr;
  logic valid;
  logic signed [7:0] u;

  logic start6;
  logic signed [5:0] err6, derr6;
  logic valid6;
  logic signed [5:0] u6;

  int n_chk;
  int n_fail;
  bit done;

  fz_infer_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .err_i(err), .derr_i(derr),
    .valid_o(valid), .u_o(u)
  );

  // R9: narrow build
  fz_infer_core #(.IN_W(6), .MU_W(4), .OUT_W(6)) dut6_i (
    .clk(clk), .rst_n(rst_n), .start(start6), .err_i(err6), .derr_i(derr6),
    .valid_o(valid6), .u_o(u6)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected results worked out by hand from R3..R8 with default tables.
  localparam int NV = 12;
  localparam int E_V [NV] = '{0, -128, 127, 112, -112, -113, 16, 48, 24, 24, -100, 111};
  localparam int D_V [NV] = '{0, -128, 127, 112, 127, -112, -48, 80, -128, 24, 0, 111};
  localparam int U_X [NV] = '{-7, -112, 112, 112, -16, -112, -16, 48, -48, 21, -56, 110};
  localparam string RQ [NV] = '{"R7", "R4", "R4", "R4", "R4", "R4",
                                "R5", "R8", "R3", "R6", "R7", "R3"};

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // One sample through the 8-bit instance; check the R2 pulse timing.
  task automatic run8(input int e, input int d, input int exp, input string req);
    @(negedge clk);
    start = 1'b1; err = 8'(e); derr = 8'(d);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    if (valid) chk("R2", "early valid", 1, 0);
    @(negedge clk);
    chk("R2", "valid at latency", int'(valid), 1);
    chk(req, $sformatf("u for e=%0d d=%0d", e, d), int'(u), exp);
    @(negedge clk);
    if (valid) chk("R2", "valid width", 1, 0);
  endtask

  task automatic run6(input int e, input int d, input int exp);
    @(negedge clk);
    start6 = 1'b1; err6 = 6'(e); derr6 = 6'(d);
    @(negedge clk);
    start6 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R9", "narrow valid", int'(valid6), 1);
    chk("R9", $sformatf("narrow u for e=%0d d=%0d", e, d), int'(u6), exp);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; start = 1'b0; err = '0; derr = '0;
    start6 = 1'b0; err6 = '0; derr6 = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid in reset", int'(valid), 0);
    chk("R1", "u in reset", int'(u), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "u after release", int'(u), 0);
    chk("R1", "valid after release", int'(valid), 0);

    // Vector table
    for (int i = 0; i < NV; i++) run8(E_V[i], D_V[i], U_X[i], RQ[i]);

    // R2: back-to-back samples give consecutive pulses in order
    @(negedge clk);
    start = 1'b1; err = 8'(-128); derr = 8'(-128);
    @(negedge clk);
    err = 8'(127); derr = 8'(127);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R2", "first of pair valid", int'(valid), 1);
    chk("R2", "first of pair u", int'(u), -112);
    @(negedge clk);
    chk("R2", "second of pair valid", int'(valid), 1);
    chk("R2", "second of pair u", int'(u), 112);

    // R2: idle inputs change, no start: no pulse, u holds
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      err = 8'(k * 20 - 60); derr = 8'(60 - k * 20);
      if (k >= 2) begin
        if (valid) chk("R2", "valid without start", 1, 0);
        if (u != 8'sd112) chk("R2", "u hold when idle", int'(u), 112);
      end
    end
    chk("R2", "u held after idle", int'(u), 112);

    // R1: reset during operation clears at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "u cleared by async reset", int'(u), 0);
    chk("R1", "valid cleared by async reset", int'(valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "u after second release", int'(u), 0);

    // R9: narrow configuration
    run6(0, 0, -1);
    run6(-32, -32, -28);
    run6(31, 31, 28);

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule